// File: doc/BRIEF.md
# PCIe Receive TLP Payload Realigner

This block sits behind a 128-bit PCI Express receive stream. Each input beat carries four dwords, lane 0 in bits [31:0]. Each beat comes with start-of-packet, end-of-packet, valid and a half-beat "empty" flag. For every packet the block lifts the 3- or 4-dword header onto a separate header port. It then re-packs the payload into a 128-bit output stream that always begins in lane 0 and carries a dword keep mask.

The lane where the payload starts depends on two things: the header size and address bit 2. With a 3-dword header the payload begins in lane 3 of the first beat if that bit is set, and in lane 0 of the next beat otherwise. With a 4-dword header it begins in lane 1 of the second beat if the bit is set, and in lane 0 otherwise. The block decodes these facts from header dword 0 and from the address dword. It counts payload dwords with the header length field. A small carry register glues the pieces together, so every output beat except the final one of a packet is full. A downstream ready stalls the output and is passed back upstream as the input ready.

Top module: `tlp_realigner`

## Requirements
- R1: After reset, out_valid and hdr_valid are low and in_ready is high.
- R2: One cycle after a start-of-packet beat is accepted, hdr_valid pulses for exactly one cycle. At the same time hdr_data carries header dwords 0..2 in lanes 0..2. Lane 3 carries header dword 3 when the header is 4 dwords and zero when it is 3. hdr_is4dw equals bit 29 of dword 0, which selects a 4-dword header.
- R3: For a 3-dword header where bit 2 of dword 2 is 1, the first payload dword is taken from lane 3 of the start beat.
- R4: For a 3-dword header where bit 2 of dword 2 is 0, lane 3 of the start beat is discarded and the payload starts at lane 0 of the next beat.
- R5: For a 4-dword header where bit 2 of dword 3 is 0, the payload starts at lane 0 of the second beat.
- R6: For a 4-dword header where bit 2 of dword 3 is 1, lane 0 of the second beat is discarded and the payload starts at its lane 1.
- R7: The payload dword count is bits [9:0] of dword 0, and a value of 0 means 1024. Output beats carry the payload in order. out_last is set only on the final beat. The final beat's keep is 0001, 0011, 0111 or 1111 for a count modulo 4 of 1, 2, 3 or 0.
- R8: Every output beat that is not the last of its packet has keep 1111.
- R9: A packet with bit 30 of dword 0 clear has no payload. It produces a header but no output data beat.
- R10: While out_valid is high and out_ready is low, out_data, out_keep and out_last hold and in_ready is low, so no dword is lost or repeated.
- R11: If the last accepted beat leaves more dwords than one output beat holds, the block emits a second, final beat. It holds in_ready low for that cycle.
- R12: A packet ends at its end-of-packet beat even if the length field asks for more. On an end beat with empty set, lanes 2 and 3 carry no payload.
- R13: Beats presented with in_valid low have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat may be taken this cycle |
| in_data | input | 128 | Four dwords, lane 0 in [31:0] |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_empty | input | 1 | On an end beat: only lanes 0 and 1 valid |
| hdr_valid | output | 1 | One-cycle header strobe |
| hdr_data | output | 128 | Header dwords, lane 3 zero for 3-dword headers |
| hdr_is4dw | output | 1 | Header is four dwords |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | 128 | Packed payload, first dword in lane 0 |
| out_keep | output | 4 | Per-lane dword valid mask |
| out_last | output | 1 | Final payload beat of the packet |

## Verification
The hardest case to reach is the overflow flush. The block has to emit one extra output beat after input has stopped. This happens only when the carry already holds dwords from an offset start and the final input beat brings enough to pass four. The stimulus sets it up on purpose with a 3-dword unaligned packet of length 5 and a 4-dword unaligned packet of length 7. It then repeats the case under random output stalls and input gaps, so the flush cycle collides with backpressure. A separate packet ends early with empty set and junk in the upper lanes, which exercises the early-end rule.

// File: rtl/tlp_rx_pkg.sv
// Shared constants and helpers for the receive realigner.
// Assumes a four-lane, 32-bit-dword bus; header fits in one beat.
package tlp_rx_pkg;
    localparam int DW_W    = 32;
    localparam int LANES   = 4;
    localparam int BUS_W   = DW_W * LANES;
    localparam int LEN_W   = 10;
    localparam int CNT_W   = LEN_W + 1;
    localparam int LCNT_W  = 3;

    typedef logic [LCNT_W-1:0] lcnt_t;
    typedef logic [CNT_W-1:0]  pcnt_t;

    // Keep mask covering the lowest n lanes (n saturates at LANES).
    function automatic logic [LANES-1:0] keep_of(input lcnt_t n);
        logic [LANES-1:0] k;
        k = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lcnt_t'(i) < n) k[i] = 1'b1;
        end
        return k;
    endfunction
endpackage

// File: rtl/tlp_hdr_decode.sv
// Header decoder: looks at a start-of-packet beat and extracts the header
// size, payload presence, address bit 2 and payload dword count.
// Assumes the header begins in lane 0 of the beat (purely combinational).
module tlp_hdr_decode
    import tlp_rx_pkg::*;
(
    input  logic [BUS_W-1:0] beat,
    output logic             is4dw,
    output logic             has_data,
    output logic             addr2,
    output pcnt_t            pay_len,
    output logic [BUS_W-1:0] hdr_out
);
    localparam int FMT_4DW_BIT  = 29;
    localparam int FMT_DATA_BIT = 30;
    localparam int ADDR_BIT     = 2;

    logic [DW_W-1:0]  dw0;
    logic [LEN_W-1:0] len_field;

    // Decode the format and length fields of header dword 0.
    always_comb begin
        dw0       = beat[DW_W-1:0];
        is4dw     = dw0[FMT_4DW_BIT];
        has_data  = dw0[FMT_DATA_BIT];
        len_field = dw0[LEN_W-1:0];
        addr2     = is4dw ? beat[3*DW_W + ADDR_BIT] : beat[2*DW_W + ADDR_BIT];
        if (!has_data)            pay_len = '0;
        else if (len_field == '0) pay_len = pcnt_t'(1) << LEN_W;
        else                      pay_len = pcnt_t'(len_field);
        hdr_out = is4dw ? beat : {{DW_W{1'b0}}, beat[3*DW_W-1:0]};
    end
endmodule

// File: rtl/tlp_lane_extract.sv
// Lane extractor: shifts the payload lanes of one beat down to lane 0 and
// clears every lane beyond the usable count.
// Assumes first_lane <= LANES and lane_lim <= LANES (combinational).
module tlp_lane_extract
    import tlp_rx_pkg::*;
(
    input  logic [BUS_W-1:0] beat,
    input  lcnt_t            first_lane,
    input  lcnt_t            lane_lim,
    input  pcnt_t            rem,
    output logic [BUS_W-1:0] ext,
    output lcnt_t            n
);
    localparam int SH_W = LCNT_W + $clog2(DW_W);

    lcnt_t            avail;
    logic [BUS_W-1:0] shifted;
    logic [LANES-1:0] lane_keep;
    logic [BUS_W-1:0] lane_mask;

    // Count usable lanes, bounded by the remaining payload.
    always_comb begin
        avail   = (lane_lim > first_lane) ? lane_lim - first_lane : '0;
        n       = (rem < pcnt_t'(avail)) ? lcnt_t'(rem) : avail;
        shifted = beat >> (SH_W'(first_lane) * SH_W'(DW_W));
        lane_keep = keep_of(n);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign lane_mask[g*DW_W +: DW_W] = {DW_W{lane_keep[g]}};
    end

    assign ext = shifted & lane_mask;
endmodule

// File: rtl/tlp_pack_stage.sv
// Packing stage: merges extracted dwords with up to LANES-1 carried dwords
// and drives the registered output beat. It holds a flush request when a
// packet's final beat overflows one output beat.
// Assumes accept is asserted only when adv is high and no flush is pending.
module tlp_pack_stage
    import tlp_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             accept,
    input  logic             done,
    input  logic [BUS_W-1:0] ext,
    input  lcnt_t            n,
    output logic             flush_pend,
    output logic             out_valid,
    output logic [BUS_W-1:0] out_data,
    output logic [LANES-1:0] out_keep,
    output logic             out_last
);
    localparam int    SH_W = LCNT_W + $clog2(DW_W);
    localparam lcnt_t FULL = lcnt_t'(LANES);

    logic [BUS_W-1:0]   carry;
    lcnt_t              ccnt;
    logic [2*BUS_W-1:0] merged;
    lcnt_t              total;

    // Append the new dwords directly above the carried ones.
    always_comb begin
        merged = {{BUS_W{1'b0}}, carry}
               | ({{BUS_W{1'b0}}, ext} << (SH_W'(ccnt) * SH_W'(DW_W)));
        total  = ccnt + n;
    end

    // Output register, carry register and flush request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_keep   <= '0;
            out_last   <= 1'b0;
            carry      <= '0;
            ccnt       <= '0;
            flush_pend <= 1'b0;
        end else if (adv) begin
            if (flush_pend) begin
                out_valid  <= 1'b1;
                out_data   <= carry;
                out_keep   <= keep_of(ccnt);
                out_last   <= 1'b1;
                carry      <= '0;
                ccnt       <= '0;
                flush_pend <= 1'b0;
            end else if (accept && total >= FULL) begin
                out_valid  <= 1'b1;
                out_data   <= merged[BUS_W-1:0];
                out_keep   <= '1;
                out_last   <= done && (total == FULL);
                carry      <= merged[2*BUS_W-1:BUS_W];
                ccnt       <= total - FULL;
                flush_pend <= done && (total > FULL);
            end else if (accept && done && total != '0) begin
                out_valid  <= 1'b1;
                out_data   <= merged[BUS_W-1:0];
                out_keep   <= keep_of(total);
                out_last   <= 1'b1;
                carry      <= '0;
                ccnt       <= '0;
            end else if (accept) begin
                out_valid  <= 1'b0;
                carry      <= merged[BUS_W-1:0];
                ccnt       <= done ? '0 : total;
            end else begin
                out_valid  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tlp_realigner.sv
// Top of the receive realigner: tracks per-packet payload position,
// captures the header and feeds the packing stage.
// Assumes well-formed start/end markers; payload extent comes from the
// length field, cut short by an end beat.
module tlp_realigner
    import tlp_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [127:0]     in_data,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic             in_empty,
    output logic             hdr_valid,
    output logic [127:0]     hdr_data,
    output logic             hdr_is4dw,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [127:0]     out_data,
    output logic [3:0]       out_keep,
    output logic             out_last
);
    localparam lcnt_t HALF = lcnt_t'(LANES / 2);

    logic             d_is4, d_has, d_addr2;
    pcnt_t            d_len;
    logic [BUS_W-1:0] d_hdr;
    pcnt_t            rem_q, rem_src;
    logic             skip_pad;
    lcnt_t            first_lane, lane_lim, n;
    logic [BUS_W-1:0] ext;
    logic             adv, accept, done, flush_pend;

    tlp_hdr_decode u_dec (
        .beat(in_data), .is4dw(d_is4), .has_data(d_has),
        .addr2(d_addr2), .pay_len(d_len), .hdr_out(d_hdr)
    );

    // Choose the first payload lane and lane limit for this beat.
    always_comb begin
        rem_src = in_sop ? d_len : rem_q;
        if (in_sop)
            first_lane = (d_has && !d_is4 && d_addr2) ? lcnt_t'(LANES - 1)
                                                      : lcnt_t'(LANES);
        else
            first_lane = skip_pad ? lcnt_t'(1) : lcnt_t'(0);
        lane_lim = (in_eop && in_empty) ? HALF : lcnt_t'(LANES);
    end

    tlp_lane_extract u_ext (
        .beat(in_data), .first_lane(first_lane), .lane_lim(lane_lim),
        .rem(rem_src), .ext(ext), .n(n)
    );

    // Handshake and end-of-payload detection.
    always_comb begin
        adv      = !out_valid || out_ready;
        in_ready = adv && !flush_pend;
        accept   = in_valid && in_ready;
        done     = in_eop || (rem_src == pcnt_t'(n));
    end

    // Per-packet position state and header capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q     <= '0;
            skip_pad  <= 1'b0;
            hdr_valid <= 1'b0;
            hdr_data  <= '0;
            hdr_is4dw <= 1'b0;
        end else begin
            hdr_valid <= accept && in_sop;
            if (accept) begin
                rem_q    <= in_eop ? '0 : rem_src - pcnt_t'(n);
                skip_pad <= in_sop && d_has && d_is4 && d_addr2;
                if (in_sop) begin
                    hdr_data  <= d_hdr;
                    hdr_is4dw <= d_is4;
                end
            end
        end
    end

    tlp_pack_stage u_pack (
        .clk(clk), .rst_n(rst_n), .adv(adv), .accept(accept), .done(done),
        .ext(ext), .n(n), .flush_pend(flush_pend), .out_valid(out_valid),
        .out_data(out_data), .out_keep(out_keep), .out_last(out_last)
    );
endmodule

// File: rtl/tlp_realigner_chk.sv
// Protocol checker for the realigner, attached by bind.
// Assumes only the port-level view of the block.
module tlp_realigner_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_ready,
    input logic         in_sop,
    input logic         hdr_valid,
    input logic         out_valid,
    input logic         out_ready,
    input logic [127:0] out_data,
    input logic [3:0]   out_keep,
    input logic         out_last
);
    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
            && $stable(out_keep) && $stable(out_last)));

    assert_stall_blocks_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    assert_full_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> (out_keep == 4'hF));

    assert_keep_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_keep == 4'h1 || out_keep == 4'h3
                       || out_keep == 4'h7 || out_keep == 4'hF));

    assert_hdr_follows_sop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> $past(in_valid && in_ready && in_sop));

    assert_flush_is_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !(out_valid && !out_ready)) |=> (out_valid && out_last));
endmodule

bind tlp_realigner tlp_realigner_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .hdr_valid(hdr_valid), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_keep(out_keep),
    .out_last(out_last)
);

// File: tb/tlp_realigner_test.sv
// Scoreboard bench: the driver queues expected headers and payload beats,
// and the monitor compares them as the design produces them.
module tlp_realigner_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_data = '0;
    logic         in_sop = 1'b0, in_eop = 1'b0, in_empty = 1'b0;
    logic         hdr_valid, hdr_is4dw;
    logic [127:0] hdr_data;
    logic         out_valid, out_last;
    logic         out_ready = 1'b1;
    logic [127:0] out_data;
    logic [3:0]   out_keep;

    int errors = 0, checks = 0, cycles = 0, pkt_id = 0, flush_seen = 0;
    bit stall_on = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [127:0] od_q[$];
    logic [3:0]   ok_q[$];
    logic         ol_q[$];
    string        ot_q[$];
    logic [127:0] hd_q[$];
    logic         h4_q[$];

    always #10 clk = ~clk;

    tlp_realigner uut (.*);

    function automatic logic [127:0] kmask(input logic [3:0] k);
        logic [127:0] m;
        for (int i = 0; i < 4; i++) m[i*32 +: 32] = {32{k[i]}};
        return m;
    endfunction

    // Output ready pattern: random when stalling is enabled.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        #1 out_ready = stall_on ? lfsr[3] : 1'b1;
    end

    // Monitor: compare headers and payload beats at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!in_ready && !(out_valid && !out_ready)) flush_seen++;
            if (hdr_valid) begin
                checks++;
                if (hd_q.size() == 0) begin
                    errors++; $display("FAIL R2: unexpected header %h expected none", hdr_data);
                end else begin
                    logic [127:0] eh; logic e4;
                    eh = hd_q.pop_front(); e4 = h4_q.pop_front();
                    if (hdr_data !== eh || hdr_is4dw !== e4) begin
                        errors++;
                        $display("FAIL R2: header %h/%b expected %h/%b", hdr_data, hdr_is4dw, eh, e4);
                    end
                end
            end
            if (out_valid && out_ready) begin
                checks++;
                if (od_q.size() == 0) begin
                    errors++; $display("FAIL R9: unexpected beat %h expected none", out_data);
                end else begin
                    logic [127:0] ed; logic [3:0] ek; logic el; string et;
                    ed = od_q.pop_front(); ek = ok_q.pop_front();
                    el = ol_q.pop_front(); et = ot_q.pop_front();
                    if (out_keep !== ek || out_last !== el
                        || (out_data & kmask(ek)) !== (ed & kmask(ek))) begin
                        errors++;
                        $display("FAIL %s: beat %h keep %h last %b expected %h keep %h last %b",
                                 et, out_data, out_keep, out_last, ed, ek, el);
                    end
                end
            end
        end
    end

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            in_valid = 1'b0; in_sop = 1'b1; in_eop = 1'b1;
            in_data = {4{32'hBAD0_0000 | 32'(i)}};   // R13: junk while invalid
            @(posedge clk); #1;
        end
        in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic put_beat(input logic [127:0] d, input logic s, input logic e, input logic em);
        in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e; in_empty = em;
        forever begin
            @(negedge clk);
            if (in_ready) break;
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_empty = 1'b0;
    endtask

    // Driver: build one packet, queue its expectations, then drive it.
    // len is the 10-bit field; act < 0 sends the full payload.
    task automatic send_pkt(input string tag, input bit is4, input bit a2,
                            input bit has, input int len, input int act, input bit gaps);
        logic [31:0] h[4];
        logic [31:0] s[];
        int pl, off, hl, nb, sent;
        pkt_id++;
        pl   = has ? ((len == 0) ? 1024 : len) : 0;
        sent = (act < 0) ? pl : act;
        hl   = is4 ? 4 : 3;
        off  = is4 ? (a2 ? 5 : 4) : (a2 ? 3 : 4);
        h[0] = {1'b0, has, is4, 19'(pkt_id), 10'(len)};
        h[1] = 32'h1000_0000 | 32'(pkt_id);
        h[2] = is4 ? 32'h0000_00AB : {28'h00C_0DE0, 1'b0, a2, 2'b00};
        h[3] = is4 ? {28'h00D_0DE0, 1'b0, a2, 2'b00} : 32'h0;
        nb   = has ? (off + sent + 3) / 4 : 1;
        s    = new[nb * 4];
        for (int j = 0; j < nb * 4; j++) s[j] = 32'hEE00_0000 | 32'(j);
        for (int j = 0; j < hl; j++) s[j] = h[j];
        for (int j = 0; j < sent; j++) s[off + j] = {8'(pkt_id), 24'(j)};
        hd_q.push_back({is4 ? h[3] : 32'h0, h[2], h[1], h[0]});
        h4_q.push_back(is4);
        for (int b = 0; b < (sent + 3) / 4; b++) begin
            logic [127:0] d; int cnt;
            cnt = (sent - b * 4 >= 4) ? 4 : sent - b * 4;
            d = '0;
            for (int i = 0; i < cnt; i++) d[i*32 +: 32] = s[off + b*4 + i];
            od_q.push_back(d);
            ok_q.push_back(4'((1 << cnt) - 1));
            ol_q.push_back(b == (sent + 3) / 4 - 1);
            ot_q.push_back(tag);
        end
        for (int b = 0; b < nb; b++) begin
            int tail; logic em;
            tail = (off + sent) % 4;
            em = (b == nb - 1) && has && (tail == 1 || tail == 2);
            if (gaps && b > 0) idle(2);
            put_beat({s[b*4+3], s[b*4+2], s[b*4+1], s[b*4]}, b == 0, b == nb - 1, em);
        end
    endtask

    // Watchdog.
    initial begin
        wait (cycles > 150000);
        errors++; checks++;
        $display("FAIL watchdog: cycles %0d expected below 150000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || hdr_valid !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1: out_valid %b hdr_valid %b in_ready %b expected 0 0 1",
                     out_valid, hdr_valid, in_ready);
        end
        @(posedge clk); #1;
        send_pkt("R3_R11", 1'b0, 1'b1, 1'b1, 5, -1, 1'b0);
        send_pkt("R4", 1'b0, 1'b0, 1'b1, 8, -1, 1'b0);
        send_pkt("R5", 1'b1, 1'b0, 1'b1, 3, -1, 1'b0);
        send_pkt("R6_R11", 1'b1, 1'b1, 1'b1, 7, -1, 1'b0);
        send_pkt("R3", 1'b0, 1'b1, 1'b1, 1, -1, 1'b0);
        send_pkt("R9", 1'b0, 1'b1, 1'b0, 6, -1, 1'b0);
        send_pkt("R9", 1'b1, 1'b0, 1'b0, 0, -1, 1'b0);
        send_pkt("R7", 1'b0, 1'b0, 1'b1, 0, -1, 1'b0);
        send_pkt("R12", 1'b0, 1'b0, 1'b1, 9, 6, 1'b0);
        send_pkt("R13", 1'b0, 1'b1, 1'b1, 13, -1, 1'b1);
        stall_on = 1'b1;
        send_pkt("R10", 1'b1, 1'b1, 1'b1, 10, -1, 1'b0);
        for (int i = 0; i < 16; i++)
            send_pkt("R8", 1'(i), 1'(i >> 1), 1'b1, 1 + (i * 5) % 11, -1, 1'(i >> 2));
        stall_on = 1'b0;
        repeat (20) @(posedge clk);
        @(negedge clk);
        checks++;
        if (od_q.size() != 0 || hd_q.size() != 0) begin
            errors++;
            $display("FAIL R9: leftover beats %0d headers %0d expected 0 0", od_q.size(), hd_q.size());
        end
        checks++;
        if (flush_seen == 0) begin
            errors++;
            $display("FAIL R11: flush cycles %0d expected at least 1", flush_seen);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule